// File: doc/BRIEF.md
# Single-Bit Sector ECC Checker

The block computes a row/column parity code over one flash sector as it streams past, one byte per beat. When the last byte has gone in, it takes the code that was stored with the sector. It compares the two codes and classifies the outcome into one of four verdicts.

For a single flipped data bit, the verdict carries the byte address and the bit index of that bit, so that a separate agent can repair the buffer. A single flipped bit inside the stored code is reported as an event that needs no data change. Anything else is reported as uncorrectable.

Data and stored code enter through valid/ready channels. The byte channel accepts a beat whenever `in_valid` and `in_ready` are both high. After the beat marked last, `in_ready` drops and stays low until the stored code has been taken. The code channel is ready only in that window and holds `code_ready` high until `code_valid` arrives. Producers may stall either channel for any number of cycles. The result pins are plain registers qualified by a one-cycle `res_done` pulse.

Top module: `hamming_sector_checker`

## Requirements
- R1: After reset, `in_ready` is 1, `code_ready` is 0 and `res_done` is 0.
- R2: Each data bit has a position made of its byte index since the start of the sector and its bit index (bit index in the low 3 bits). Half `odd` bit k is the XOR of all data bits whose position has bit k set. Half `even` bit k is the XOR of all data bits whose position has bit k clear. The code is the bitwise inverse of {odd, even}, with `odd` in the upper half. `code_in` bits 7:0 carry the first stored byte, bits 15:8 the next, and so on. As a result, a sector of all 0xFF with a stored code of all ones checks clean.
- R3: A byte is accepted only when `in_valid` and `in_ready` are both high. After the last byte is accepted, `in_ready` is 0 and `code_ready` is 1 until a code is accepted. Bytes offered in that window are ignored.
- R4: `res_done` is 1 in exactly the cycle after the code is accepted, and 0 in the cycle after that.
- R5: A difference of zero between the computed and stored codes gives verdict 0 (clean).
- R6: A difference whose upper half XOR lower half is all ones gives verdict 1 (data bit fixed), provided the byte field is below SECTOR_BYTES. The byte field is the upper half's top bits and goes to `res_byte`; the upper half's low 3 bits go to `res_bit`.
- R7: A difference of that complementary form whose byte field is SECTOR_BYTES or more gives verdict 3 (uncorrectable).
- R8: A difference with exactly one bit set gives verdict 2 (error in the stored code, no data change).
- R9: Any other nonzero difference gives verdict 3.
- R10: A beat with `in_first` set restarts the sector at byte 0 and discards any earlier partial accumulation.
- R11: `res_byte` and `res_bit` are 0 whenever the verdict is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Data byte can be taken |
| in_data | input | 8 | Sector byte |
| in_first | input | 1 | Beat is byte 0 of a sector |
| in_last | input | 1 | Beat is the final byte of a sector |
| code_valid | input | 1 | Stored code offered |
| code_ready | output | 1 | Stored code can be taken |
| code_in | input | CODE_W (24) | Stored code, first stored byte in bits 7:0 |
| res_done | output | 1 | One-cycle pulse: result fields valid |
| res_kind | output | 2 | 0 clean, 1 data bit fixed, 2 code bit error, 3 uncorrectable |
| res_byte | output | ADDR_W (9) | Byte address of the faulty data bit |
| res_bit | output | 3 | Bit index of the faulty data bit |

## Verification
The bench builds the block with SECTOR_BYTES set to 12. This gives a 4-bit byte field and a 14-bit code. Byte-field values 12 to 15 are representable but lie outside the sector, so the out-of-range rule becomes reachable; the default 512-byte power-of-two sector can never produce it. The short sectors also let the bench cover first, middle and final-byte flips, stalls on both channels, and restarts cheaply.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    VERDICT_CLEAN    = 2'd0,
    VERDICT_DATA_FIX = 2'd1,
    VERDICT_CODE_BIT = 2'd2,
    VERDICT_UNCORR   = 2'd3
  } verdict_e;

  typedef enum logic {
    ST_DATA = 1'b0,
    ST_CODE = 1'b1
  } seq_state_e;

  // Byte lanes whose bit index has bit k set.
  function automatic logic [7:0] bitpos_mask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/hsc_parity_accum.sv
module hsc_parity_accum #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic [7:0]        data,
  output logic [HALF_W-1:0] odd_par,
  output logic [HALF_W-1:0] even_par
);
  import hsc_pkg::*;

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] cnt_base;
  logic [HALF_W-1:0] odd_q, even_q;
  logic [HALF_W-1:0] odd_c, even_c;
  logic              byte_par;

  assign cnt_base = first ? '0 : cnt_q;
  assign byte_par = ^data;

  // Bit-index part of the position: selected lanes inside one byte.
  for (genvar k = 0; k < 3; k++) begin : g_bitpos
    localparam logic [7:0] LANES = bitpos_mask(k);
    assign odd_c[k]  = ^(data & LANES);
    assign even_c[k] = ^(data & ~LANES);
  end

  // Byte-address part: whole-byte parity steered by the address bit.
  for (genvar k = 3; k < HALF_W; k++) begin : g_bytepos
    assign odd_c[k]  = cnt_base[k-3] & byte_par;
    assign even_c[k] = ~cnt_base[k-3] & byte_par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      odd_q  <= '0;
      even_q <= '0;
    end else if (beat) begin
      cnt_q  <= cnt_base + ADDR_W'(1);
      odd_q  <= (first ? '0 : odd_q) ^ odd_c;
      even_q <= (first ? '0 : even_q) ^ even_c;
    end
  end

  assign odd_par  = odd_q;
  assign even_par = even_q;

  // R10: a restart beat leaves exactly one byte counted.
  p_restart_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat && first |=> cnt_q == ADDR_W'(1));

endmodule

// File: rtl/hsc_classify.sv
module hsc_classify #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES),
  parameter int HALF_W       = ADDR_W + 3,
  parameter int CODE_W       = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] odd_par,
  input  logic [HALF_W-1:0] even_par,
  input  logic [CODE_W-1:0] stored,
  output hsc_pkg::verdict_e kind,
  output logic [ADDR_W-1:0] err_byte,
  output logic [2:0]        err_bit
);
  import hsc_pkg::*;

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] computed, diff;
  logic [HALF_W-1:0] hi, lo;
  logic [ADDR_W-1:0] cand_byte;
  logic [2:0]        cand_bit;
  logic              is_zero, is_mirror, is_single, in_range;

  assign computed  = ~{odd_par, even_par};
  assign diff      = computed ^ stored;
  assign hi        = diff[CODE_W-1:HALF_W];
  assign lo        = diff[HALF_W-1:0];
  assign cand_byte = hi[HALF_W-1:3];
  assign cand_bit  = hi[2:0];
  assign is_zero   = (diff == '0);
  assign is_mirror = &(hi ^ lo);
  assign is_single = !is_zero && ((diff & (diff - CODE_W'(1))) == '0);
  assign in_range  = {1'b0, cand_byte} < LIMIT;

  always_comb begin
    kind     = VERDICT_UNCORR;
    err_byte = '0;
    err_bit  = '0;
    if (is_zero) begin
      kind = VERDICT_CLEAN;
    end else if (is_mirror) begin
      if (in_range) begin
        kind     = VERDICT_DATA_FIX;
        err_byte = cand_byte;
        err_bit  = cand_bit;
      end
    end else if (is_single) begin
      kind = VERDICT_CODE_BIT;
    end
  end

endmodule

// File: rtl/hsc_seq.sv
module hsc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic code_valid,
  output logic in_ready,
  output logic code_ready,
  output logic beat,
  output logic code_take
);
  import hsc_pkg::*;

  seq_state_e state_q, state_d;

  assign in_ready   = (state_q == ST_DATA);
  assign code_ready = (state_q == ST_CODE);
  assign beat       = in_valid && in_ready;
  assign code_take  = code_valid && code_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_DATA: if (beat && in_last) state_d = ST_CODE;
      ST_CODE: if (code_take)       state_d = ST_DATA;
      default:                      state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DATA;
    else        state_q <= state_d;
  end

  // R3: the last byte closes the data channel and opens the code channel.
  p_stall_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready && code_ready);

  // R3: the code channel waits as long as the producer stalls.
  p_code_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready && !code_valid |=> code_ready && !in_ready);

endmodule

// File: rtl/hamming_sector_checker.sv
module hamming_sector_checker #(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int HALF_W      = ADDR_W + 3,
  localparam int CODE_W      = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_in,
  output logic              res_done,
  output logic [1:0]        res_kind,
  output logic [ADDR_W-1:0] res_byte,
  output logic [2:0]        res_bit
);
  import hsc_pkg::*;

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SECTOR_BYTES);

  logic              beat, code_take;
  logic [HALF_W-1:0] odd_par, even_par;
  verdict_e          kind_c;
  logic [ADDR_W-1:0] byte_c;
  logic [2:0]        bit_c;

  hsc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .code_valid (code_valid),
    .in_ready   (in_ready),
    .code_ready (code_ready),
    .beat       (beat),
    .code_take  (code_take)
  );

  hsc_parity_accum #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .ADDR_W       (ADDR_W),
    .HALF_W       (HALF_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .first    (in_first),
    .data     (in_data),
    .odd_par  (odd_par),
    .even_par (even_par)
  );

  hsc_classify #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .ADDR_W       (ADDR_W),
    .HALF_W       (HALF_W),
    .CODE_W       (CODE_W)
  ) u_classify (
    .odd_par  (odd_par),
    .even_par (even_par),
    .stored   (code_in),
    .kind     (kind_c),
    .err_byte (byte_c),
    .err_bit  (bit_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done <= 1'b0;
      res_kind <= 2'd0;
      res_byte <= '0;
      res_bit  <= '0;
    end else begin
      res_done <= code_take;
      if (code_take) begin
        res_kind <= kind_c;
        res_byte <= byte_c;
        res_bit  <= bit_c;
      end
    end
  end

  // R4: a taken code yields a result on the next cycle.
  p_done_after_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && code_ready |=> res_done && in_ready);

  // R4: the done flag is a single-cycle pulse.
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R11: location fields are quiet unless a data bit was fixed.
  p_fields_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_kind != 2'd1 |-> res_byte == '0 && res_bit == '0);

  // R6: a fixed data bit always lies inside the sector.
  p_fix_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_kind == 2'd1 |-> {1'b0, res_byte} < LIMIT);

endmodule

// File: tb/hamming_sector_checker_tb.sv
module hamming_sector_checker_tb;
  localparam int SB = 12;
  localparam int AW = 4;
  localparam int HW = AW + 3;
  localparam int CW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'h00;
  logic          in_first = 1'b0;
  logic          in_last = 1'b0;
  logic          code_valid = 1'b0;
  logic          code_ready;
  logic [CW-1:0] code_in = '0;
  logic          res_done;
  logic [1:0]    res_kind;
  logic [AW-1:0] res_byte;
  logic [2:0]    res_bit;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [SB];

  always #10 clk = ~clk;

  hamming_sector_checker #(.SECTOR_BYTES(SB)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_first   (in_first),
    .in_last    (in_last),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_in    (code_in),
    .res_done   (res_done),
    .res_kind   (res_kind),
    .res_byte   (res_byte),
    .res_bit    (res_bit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Code per R2, computed from the bench copy of the sector.
  function automatic logic [CW-1:0] model_code();
    logic [HW-1:0] o, e;
    logic [HW-1:0] p;
    o = '0;
    e = '0;
    for (int i = 0; i < SB; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          p = {AW'(i), 3'(b)};
          for (int k = 0; k < HW; k++)
            if (p[k]) o[k] = ~o[k];
            else      e[k] = ~e[k];
        end
    return ~{o, e};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < SB; i++) mem[i] = 8'((i * 73 + seed * 29 + 5) ^ (i << 3));
  endtask

  task automatic run_sector(input string req, input int gap, input int stall,
                            input logic [CW-1:0] stored,
                            input int ek, input int eb, input int ebit);
    for (int i = 0; i < SB; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = mem[i];
      in_first = (i == 0); in_last = (i == SB - 1);
      if (gap > 0 && i != SB - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    check("R3", "in_ready after last", int'(in_ready), 0);
    check("R3", "code_ready after last", int'(code_ready), 1);
    for (int s = 0; s < stall; s++) begin
      in_valid = 1'b1; in_data = 8'h5A; in_first = 1'b1; in_last = 1'b1;
      @(negedge clk);
      check("R3", "in_ready while stalled", int'(in_ready), 0);
      check("R3", "no done while stalled", int'(res_done), 0);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    code_valid = 1'b1; code_in = stored;
    @(negedge clk);
    code_valid = 1'b0;
    check("R4", "done after code", int'(res_done), 1);
    check(req, "verdict", int'(res_kind), ek);
    check(req, "byte", int'(res_byte), eb);
    check(req, "bit", int'(res_bit), ebit);
    @(negedge clk);
    check("R4", "done single cycle", int'(res_done), 0);
    check("R4", "in_ready restored", int'(in_ready), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "in_ready", int'(in_ready), 1);
    check("R1", "code_ready", int'(code_ready), 0);
    check("R1", "res_done", int'(res_done), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_clean();
    fill(1); run_sector("R5", 0, 0, model_code(), 0, 0, 0);
    fill(2); run_sector("R5", 1, 0, model_code(), 0, 0, 0);
  endtask

  task automatic t_erased();
    for (int i = 0; i < SB; i++) mem[i] = 8'hFF;
    run_sector("R2", 0, 0, {CW{1'b1}}, 0, 0, 0);
  endtask

  task automatic t_data_fix(input int seed, input int at, input int b);
    logic [CW-1:0] c;
    fill(seed);
    c = model_code();
    mem[at][b] = ~mem[at][b];
    run_sector("R6", 0, 0, c, 1, at, b);
  endtask

  task automatic t_code_bit();
    logic [CW-1:0] c;
    fill(4);
    c = model_code();
    run_sector("R8", 0, 0, c ^ CW'(1 << 9), 2, 0, 0);
    run_sector("R8", 0, 0, c ^ CW'(1), 2, 0, 0);
  endtask

  task automatic t_uncorr();
    logic [CW-1:0] c;
    fill(5);
    c = model_code();
    mem[1][2] = ~mem[1][2];
    mem[2][6] = ~mem[2][6];
    run_sector("R9", 0, 0, c, 3, 0, 0);
    fill(5);
    run_sector("R9", 0, 0, c ^ CW'(3), 3, 0, 0);
  endtask

  task automatic t_range();
    logic [CW-1:0] c;
    logic [HW-1:0] h;
    fill(6);
    c = model_code();
    h = {4'd12, 3'd5};
    run_sector("R7", 0, 0, c ^ {h, ~h}, 3, 0, 0);
    h = {4'd15, 3'd0};
    run_sector("R7", 0, 0, c ^ {h, ~h}, 3, 0, 0);
  endtask

  task automatic t_stall();
    fill(7);
    run_sector("R3", 0, 3, model_code(), 0, 0, 0);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(i * 37 + 1);
      in_first = (i == 0); in_last = 1'b0;
    end
    fill(8);
    run_sector("R10", 0, 0, model_code(), 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_clean();
    t_erased();
    t_data_fix(3, 5, 3);
    t_data_fix(9, 0, 0);
    t_data_fix(10, SB - 1, 7);
    t_code_bit();
    t_uncorr();
    t_range();
    t_stall();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule